// File: doc/BRIEF.md
# Two-Channel Sample Threshold Monitor

This block watches a stream of signed converter samples that arrive several to a clock cycle, packed side by side in one wide word. Two threshold channels examine the same stream at the same time. Each channel has its own operating mode, its own pair of limits and its own run length, and it drives one registered status flag.

A channel can work in one of three modes. In the first, its flag latches when any sample rises above the upper limit. In the second, its flag latches after an unbroken run of samples below the lower limit. In the third, the flag follows the signal with hysteresis: it rises on a sample above the upper limit and falls only after a qualified run below the lower limit. The two latching modes hold their flag until a clear pulse arrives. The configuration inputs are static. They are copied into the channels on a single load strobe, so the surrounding logic can change them freely between loads.

Top module: `adc_thr_monitor`

## Requirements
- R1: There are two independent channels. Channel c takes its mode from `cfg_mode_i[2c+1:2c]`, coded 0 = latch-above, 1 = latch-below-run, 2 = hysteresis and 3 = off. A channel in the off mode holds its flag low.
- R2: Lane i of a cycle sits in `samples_i[16i+15:16i]`. Lanes are evaluated from lane 0 upward, and a run of below-limit samples carries across cycle boundaries.
- R3: Samples and limits are compared as two's-complement numbers. A sample equal to a limit counts as neither above nor below it.
- R4: In latch-above mode the flag sets when a valid sample is greater than the upper limit. It then holds until a clear.
- R5: In latch-below-run mode the flag sets once the count of consecutive valid samples below the lower limit reaches the programmed run length. It then holds until a clear. Any sample that is not below the limit restarts the run.
- R6: In hysteresis mode the flag sets on a sample above the upper limit. It falls once the consecutive below-lower run reaches the run length. A sample between the limits, or above the upper limit, restarts the run. The clear input has no effect in this mode.
- R7: A programmed run length of 0 behaves as a run length of 1.
- R8: The clear input drops the flag and the run in both latching modes. When a clear and a setting sample fall in the same cycle, the flag ends that cycle high.
- R9: While `samples_vld_i` is low, the samples do not change the flags or the runs.
- R10: A cycle with `cfg_load_i` high copies the configuration, clears all flags and runs, and ignores that cycle's samples.
- R11: The flags are registered and are low after reset. The result for a sample cycle appears on `flag_o` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samples_i | input | LANES*SAMP_W | Packed samples, lane 0 in the low bits |
| samples_vld_i | input | 1 | Samples in this cycle are valid |
| clear_i | input | 1 | Clear pulse for the latching modes |
| cfg_load_i | input | 1 | Load strobe for the configuration inputs |
| cfg_mode_i | input | 4 | Per-channel mode, 2 bits each |
| cfg_upper_i | input | 2*SAMP_W | Per-channel upper limits |
| cfg_lower_i | input | 2*SAMP_W | Per-channel lower limits |
| cfg_count_i | input | 2*CNT_W | Per-channel run lengths |
| flag_o | output | 2 | Per-channel status flags |

## Verification
The bench targets the following corner cases:
- A sample exactly equal to a limit. A design that treated it as crossing the limit would set the flag one sample too early.
- The most negative sample against a positive upper limit. An unsigned compare would latch falsely on it.
- A run that starts in one cycle and finishes in the next. A design that reset the run counter every cycle would never latch.
- An upper-limit crossing followed by a qualifying run in the same word, and the reverse order in the next word. A design that evaluated the lanes in the wrong order would end with the opposite flag.
- A clear that arrives together with a setting sample. A design where the clear wins would leave the flag low.
- A load cycle carrying samples that would set the flag. A design that kept those samples would show a flag high right after the load.

// File: rtl/adc_thr_pkg.sv
package adc_thr_pkg;
   localparam int THR_CH = 2;

   typedef enum logic [1:0] {
      MODE_OVER  = 2'd0,
      MODE_UNDER = 2'd1,
      MODE_HYST  = 2'd2,
      MODE_OFF   = 2'd3
   } thr_mode_e;
endpackage

// File: rtl/adc_thr_cfg_reg.sv
module adc_thr_cfg_reg
   import adc_thr_pkg::*;
#(
   parameter int SAMP_W = 16,
   parameter int CNT_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic [1:0]               mode_i,
   input  logic [SAMP_W-1:0]        upper_i,
   input  logic [SAMP_W-1:0]        lower_i,
   input  logic [CNT_W-1:0]         count_i,
   output thr_mode_e                mode_q,
   output logic signed [SAMP_W-1:0] upper_q,
   output logic signed [SAMP_W-1:0] lower_q,
   output logic [CNT_W-1:0]         target_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] target_d;

   // a zero run length is promoted to one at load time
   assign target_d = (count_i == '0) ? ONE : count_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_OFF;
         upper_q  <= '0;
         lower_q  <= '0;
         target_q <= ONE;
      end else if (load_i) begin
         mode_q   <= thr_mode_e'(mode_i);
         upper_q  <= upper_i;
         lower_q  <= lower_i;
         target_q <= target_d;
      end
   end
endmodule

// File: rtl/adc_thr_lane_step.sv
module adc_thr_lane_step
   import adc_thr_pkg::*;
#(
   parameter int SAMP_W = 16,
   parameter int CNT_W  = 12
) (
   input  thr_mode_e                mode_i,
   input  logic signed [SAMP_W-1:0] sample_i,
   input  logic signed [SAMP_W-1:0] upper_i,
   input  logic signed [SAMP_W-1:0] lower_i,
   input  logic [CNT_W-1:0]         target_i,
   input  logic                     flag_i,
   input  logic [CNT_W-1:0]         run_i,
   output logic                     flag_o,
   output logic [CNT_W-1:0]         run_o
);
   logic             above;
   logic             below;
   logic [CNT_W-1:0] run_inc;

   assign above   = sample_i > upper_i;
   assign below   = sample_i < lower_i;
   assign run_inc = (run_i >= target_i) ? target_i : run_i + CNT_W'(1);

   always_comb begin
      flag_o = flag_i;
      run_o  = run_i;
      unique case (mode_i)
         MODE_OVER: begin
            run_o = '0;
            if (above) flag_o = 1'b1;
         end
         MODE_UNDER: begin
            if (below) begin
               run_o = run_inc;
               if (run_inc >= target_i) flag_o = 1'b1;
            end else begin
               run_o = '0;
            end
         end
         MODE_HYST: begin
            if (above) begin
               flag_o = 1'b1;
               run_o  = '0;
            end else if (below) begin
               run_o = run_inc;
               if (run_inc >= target_i) flag_o = 1'b0;
            end else begin
               run_o = '0;
            end
         end
         default: begin
            flag_o = 1'b0;
            run_o  = '0;
         end
      endcase
   end
endmodule

// File: rtl/adc_thr_channel.sv
module adc_thr_channel
   import adc_thr_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int SAMP_W = 16,
   parameter int CNT_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES*SAMP_W-1:0] samples_i,
   input  logic                    vld_i,
   input  logic                    clear_i,
   input  logic                    load_i,
   input  logic [1:0]              mode_i,
   input  logic [SAMP_W-1:0]       upper_i,
   input  logic [SAMP_W-1:0]       lower_i,
   input  logic [CNT_W-1:0]        count_i,
   output logic                    flag_o,
   output thr_mode_e               mode_o
);
   thr_mode_e                mode_q;
   logic signed [SAMP_W-1:0] upper_q;
   logic signed [SAMP_W-1:0] lower_q;
   logic [CNT_W-1:0]         target_q;

   logic                     flag_q;
   logic [CNT_W-1:0]         run_q;
   logic                     latching;
   logic                     flag_c [LANES+1];
   logic [CNT_W-1:0]         run_c  [LANES+1];

   adc_thr_cfg_reg #(.SAMP_W(SAMP_W), .CNT_W(CNT_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .mode_i   (mode_i),
      .upper_i  (upper_i),
      .lower_i  (lower_i),
      .count_i  (count_i),
      .mode_q   (mode_q),
      .upper_q  (upper_q),
      .lower_q  (lower_q),
      .target_q (target_q)
   );

   // clear acts before the lanes, so a setting sample in the same word wins
   assign latching  = (mode_q == MODE_OVER) || (mode_q == MODE_UNDER);
   assign flag_c[0] = (clear_i && latching) ? 1'b0 : flag_q;
   assign run_c[0]  = (clear_i && latching) ? '0   : run_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      adc_thr_lane_step #(.SAMP_W(SAMP_W), .CNT_W(CNT_W)) u_step (
         .mode_i   (mode_q),
         .sample_i (samples_i[l*SAMP_W +: SAMP_W]),
         .upper_i  (upper_q),
         .lower_i  (lower_q),
         .target_i (target_q),
         .flag_i   (flag_c[l]),
         .run_i    (run_c[l]),
         .flag_o   (flag_c[l+1]),
         .run_o    (run_c[l+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         run_q  <= '0;
      end else if (load_i) begin
         flag_q <= 1'b0;
         run_q  <= '0;
      end else if (vld_i) begin
         flag_q <= flag_c[LANES];
         run_q  <= run_c[LANES];
      end else begin
         flag_q <= flag_c[0];
         run_q  <= run_c[0];
      end
   end

   assign flag_o = flag_q;
   assign mode_o = mode_q;
endmodule

// File: rtl/adc_thr_monitor.sv
module adc_thr_monitor
   import adc_thr_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int SAMP_W = 16,
   parameter int CNT_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANES*SAMP_W-1:0]  samples_i,
   input  logic                     samples_vld_i,
   input  logic                     clear_i,
   input  logic                     cfg_load_i,
   input  logic [2*THR_CH-1:0]      cfg_mode_i,
   input  logic [THR_CH*SAMP_W-1:0] cfg_upper_i,
   input  logic [THR_CH*SAMP_W-1:0] cfg_lower_i,
   input  logic [THR_CH*CNT_W-1:0]  cfg_count_i,
   output logic [THR_CH-1:0]        flag_o
);
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("adc_thr_monitor: LANES must lie in 1..16");
   end
   if (SAMP_W < 2) begin : g_bad_width
      $error("adc_thr_monitor: SAMP_W must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 31) begin : g_bad_count
      $error("adc_thr_monitor: CNT_W must lie in 1..31");
   end

   logic [2*THR_CH-1:0] act_mode;

   for (genvar c = 0; c < THR_CH; c++) begin : g_ch
      thr_mode_e ch_mode;

      adc_thr_channel #(.LANES(LANES), .SAMP_W(SAMP_W), .CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .samples_i (samples_i),
         .vld_i     (samples_vld_i),
         .clear_i   (clear_i),
         .load_i    (cfg_load_i),
         .mode_i    (cfg_mode_i[2*c +: 2]),
         .upper_i   (cfg_upper_i[c*SAMP_W +: SAMP_W]),
         .lower_i   (cfg_lower_i[c*SAMP_W +: SAMP_W]),
         .count_i   (cfg_count_i[c*CNT_W +: CNT_W]),
         .flag_o    (flag_o[c]),
         .mode_o    (ch_mode)
      );

      assign act_mode[2*c +: 2] = ch_mode;
   end
endmodule

// File: rtl/adc_thr_monitor_chk.sv
module adc_thr_monitor_chk
   import adc_thr_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                samples_vld_i,
   input logic                clear_i,
   input logic                cfg_load_i,
   input logic [THR_CH-1:0]   flag_o,
   input logic [2*THR_CH-1:0] act_mode
);
   for (genvar c = 0; c < THR_CH; c++) begin : g_chk
      logic [1:0] m;
      assign m = act_mode[2*c +: 2];

      a_r10_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_load_i |=> !flag_o[c]);

      a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!samples_vld_i && !clear_i && !cfg_load_i) |=> $stable(flag_o[c]));

      a_r4_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (m == 2'(MODE_OVER) && flag_o[c] && !clear_i && !cfg_load_i) |=> flag_o[c]);

      a_r6_hyst_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (m == 2'(MODE_HYST) && !samples_vld_i && !cfg_load_i) |=> $stable(flag_o[c]));

      a_r11_rise_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_o[c]) |-> ($past(samples_vld_i) && !$past(cfg_load_i)));

      a_r1_off_low: assert property (@(posedge clk) disable iff (!rst_n)
         (m == 2'(MODE_OFF)) |-> !flag_o[c]);
   end
endmodule

bind adc_thr_monitor adc_thr_monitor_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .samples_vld_i (samples_vld_i),
   .clear_i       (clear_i),
   .cfg_load_i    (cfg_load_i),
   .flag_o        (flag_o),
   .act_mode      (act_mode)
);

// File: tb/adc_thr_monitor_tb.sv
module adc_thr_monitor_tb;
   import adc_thr_pkg::*;

   localparam int LANES  = 4;
   localparam int SAMP_W = 16;
   localparam int CNT_W  = 12;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic [LANES*SAMP_W-1:0]  samples_i = '0;
   logic                     samples_vld_i = 1'b0;
   logic                     clear_i = 1'b0;
   logic                     cfg_load_i = 1'b0;
   logic [2*THR_CH-1:0]      cfg_mode_i = '1;
   logic [THR_CH*SAMP_W-1:0] cfg_upper_i = '0;
   logic [THR_CH*SAMP_W-1:0] cfg_lower_i = '0;
   logic [THR_CH*CNT_W-1:0]  cfg_count_i = '0;
   logic [THR_CH-1:0]        flag_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   adc_thr_monitor #(.LANES(LANES), .SAMP_W(SAMP_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .samples_i(samples_i), .samples_vld_i(samples_vld_i),
      .clear_i(clear_i), .cfg_load_i(cfg_load_i), .cfg_mode_i(cfg_mode_i),
      .cfg_upper_i(cfg_upper_i), .cfg_lower_i(cfg_lower_i), .cfg_count_i(cfg_count_i),
      .flag_o(flag_o)
   );

   task automatic check(input int ch, input logic exp, input string req);
      n_chk++;
      if (flag_o[ch] !== exp) begin
         n_bad++;
         $display("FAIL %s: channel %0d flag actual %b expected %b", req, ch, flag_o[ch], exp);
      end
   endtask

   task automatic set_ch(input int ch, input thr_mode_e md, input int up, input int lo, input int cnt);
      cfg_mode_i[2*ch +: 2]           = md;
      cfg_upper_i[ch*SAMP_W +: SAMP_W] = up[SAMP_W-1:0];
      cfg_lower_i[ch*SAMP_W +: SAMP_W] = lo[SAMP_W-1:0];
      cfg_count_i[ch*CNT_W +: CNT_W]   = cnt[CNT_W-1:0];
   endtask

   // one load cycle; optional samples on the same cycle must be ignored
   task automatic load(input logic vld, input int s);
      samples_i     = {LANES{s[SAMP_W-1:0]}};
      samples_vld_i = vld;
      cfg_load_i    = 1'b1;
      @(negedge clk);
      cfg_load_i    = 1'b0;
      samples_vld_i = 1'b0;
   endtask

   task automatic step(input int a, input int b, input int c, input int d,
                       input logic vld, input logic clr);
      samples_i     = {d[SAMP_W-1:0], c[SAMP_W-1:0], b[SAMP_W-1:0], a[SAMP_W-1:0]};
      samples_vld_i = vld;
      clear_i       = clr;
      @(negedge clk);
      samples_vld_i = 1'b0;
      clear_i       = 1'b0;
   endtask

   task automatic t_reset();
      check(0, 1'b0, "R11 reset");
      check(1, 1'b0, "R11 reset");
   endtask

   task automatic t_over();
      set_ch(0, MODE_OVER, 100, 0, 1);
      set_ch(1, MODE_OFF, 0, 0, 1);
      load(1'b0, 0);
      step(-32768, 100, 50, 0, 1'b1, 1'b0);
      check(0, 1'b0, "R3 signed compare and equal not above");
      step(0, 0, 101, 0, 1'b1, 1'b0);
      check(0, 1'b1, "R4 set above upper");
      step(0, 0, 0, 0, 1'b1, 1'b0);
      check(0, 1'b1, "R4 sticky hold");
      step(0, 0, 0, 0, 1'b1, 1'b1);
      check(0, 1'b0, "R8 clear drops latch");
      step(0, 0, 0, 500, 1'b1, 1'b1);
      check(0, 1'b1, "R8 trigger beats clear");
      step(0, 0, 0, 0, 1'b0, 1'b1);
      step(30000, 30000, 30000, 30000, 1'b0, 1'b0);
      check(0, 1'b0, "R9 invalid samples ignored");
      step(30000, 0, 0, 0, 1'b1, 1'b0);
      check(1, 1'b0, "R1 off channel stays low");
   endtask

   task automatic t_under();
      set_ch(0, MODE_OVER, 100, 0, 1);
      set_ch(1, MODE_UNDER, 0, -10, 6);
      load(1'b0, 0);
      step(-20, -20, -20, -10, 1'b1, 1'b0);
      check(1, 1'b0, "R5 equal sample breaks run");
      step(-20, -20, -20, -20, 1'b1, 1'b0);
      check(1, 1'b0, "R5 run of four short of six");
      step(-20, 0, -20, -20, 1'b1, 1'b0);
      check(1, 1'b0, "R5 non-below sample restarts run");
      step(-20, -20, -20, -20, 1'b1, 1'b0);
      check(1, 1'b1, "R2 run spans cycle boundary");
      check(0, 1'b0, "R1 channels independent");
      step(0, 0, 0, 0, 1'b1, 1'b0);
      check(1, 1'b1, "R5 sticky hold");
      step(0, 0, 0, 0, 1'b1, 1'b1);
      check(1, 1'b0, "R8 clear in under mode");
   endtask

   task automatic t_count_zero();
      set_ch(1, MODE_UNDER, 0, 0, 0);
      load(1'b0, 0);
      step(0, 0, 0, -1, 1'b1, 1'b0);
      check(1, 1'b1, "R7 zero run length acts as one");
      load(1'b1, -5);
      check(1, 1'b0, "R10 load clears and ignores its samples");
   endtask

   task automatic t_hyst();
      set_ch(0, MODE_HYST, 1000, -1000, 3);
      set_ch(1, MODE_OFF, 0, 0, 1);
      load(1'b0, 0);
      step(1001, 0, 0, 0, 1'b1, 1'b0);
      check(0, 1'b1, "R6 rise above upper");
      step(-1001, -1001, 0, 0, 1'b1, 1'b0);
      check(0, 1'b1, "R6 short run does not release");
      step(0, 0, 0, 0, 1'b1, 1'b1);
      check(0, 1'b1, "R6 clear has no effect");
      step(-1001, -1001, -1001, 0, 1'b1, 1'b0);
      check(0, 1'b0, "R6 release after run");
      step(2000, -2000, -2000, -2000, 1'b1, 1'b0);
      check(0, 1'b0, "R2 lane order rise then release");
      step(-2000, -2000, -2000, 2000, 1'b1, 1'b0);
      check(0, 1'b1, "R2 lane order last lane rises");
      load(1'b0, 0);
      check(0, 1'b0, "R10 load clears hysteresis flag");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_over();
      t_under();
      t_count_zero();
      t_hyst();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule